// File: doc/BRIEF.md
# Radiation Upset Memory Monitor

The block watches two storage targets on the chip for bit flips caused by radiation: a RAM bank that maps onto block RAM and a smaller bank of flip-flop registers. It runs a test loop again and again. Each pass writes a checkerboard of ones and zeros into every word of both targets. It then leaves the targets alone for a long dwell interval (one second at the system clock by default). After the dwell it reads every word back, XORs it against the pattern it expects, and counts the set bits of the result. The count for the RAM and the count for the registers are kept apart.

When the readback ends, the block offers a record with a valid/ready handshake. The record holds the pass index, the RAM error count and the register error count. The loop stalls until a logger accepts the record. A level `run` input starts the loop and stops it at the end of a pass. Two saturating totals and the current phase are visible at all times. The checkerboard changes polarity on every pass, so over two passes each cell holds both values.

For testing on the bench and for fault campaigns, an upset-emulation port can overwrite any word of either target while the block is in the dwell phase. This stands in for the radiation.

Top module: `rad_upset_monitor`

## Requirements
- R1: After a synchronous active-high reset, `st_phase` is 0 (idle), `rec_valid` is 0 and both totals are 0. The block stays idle while `run` is low.
- R2: In pass n (the first pass after reset is n = 0), bit j of word a in both targets is written as 1 exactly when j + a + n is even. A pass with no upsets reports 0 errors for both targets.
- R3: `rec_ram_err` equals the sum over all RAM words of the number of bits in which the word read back differs from the R2 pattern.
- R4: `rec_reg_err` is counted in the same way for the register bank only, independently of the RAM count.
- R5: Phase codes on `st_phase` are idle=0, write=1, dwell=2, read=3, drain=4, report=5. They follow the order 1,2,3,4,5. The dwell phase lasts exactly DWELL_CYCLES clock cycles.
- R6: During dwell, `inj_en` writes `inj_data` into word `inj_addr` of the RAM (`inj_sel`=0) or of the register bank (`inj_sel`=1). An address beyond the selected target's depth changes nothing.
- R7: `rec_valid` rises once per pass, carrying `rec_idx` = n. While `rec_ready` is low, the record and the phase (5) are held stable. The index advances by one with each accepted record.
- R8: When a record is accepted, the block goes back to idle if `run` is low. When `run` is raised again, the next pass starts with the following index and the totals are unchanged.
- R9: On each accepted record, `st_ram_total` and `st_reg_total` add that record's counts and saturate at all ones (TOT_W bits).
- R10: With `run` held high, the write phase of the next pass begins in the cycle right after the record is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Loop enable, sampled at idle and at record acceptance |
| inj_en | input | 1 | Upset emulation write strobe, active in dwell only |
| inj_sel | input | 1 | Emulation target: 0 RAM, 1 registers |
| inj_addr | input | $clog2(max(RAM_WORDS,REG_WORDS)) | Emulation word address |
| inj_data | input | DATA_W | Word value to place in the target |
| rec_valid | output | 1 | Pass record valid |
| rec_ready | input | 1 | Logger accepts record |
| rec_idx | output | IDX_W | Pass index of the record |
| rec_ram_err | output | $clog2(RAM_WORDS*DATA_W+1) | Flipped RAM bits in the pass |
| rec_reg_err | output | $clog2(REG_WORDS*DATA_W+1) | Flipped register bits in the pass |
| st_phase | output | 3 | Current phase code |
| st_ram_total | output | TOT_W | Saturating RAM error total |
| st_reg_total | output | TOT_W | Saturating register error total |

## Verification
The bench places words whose flipped-bit counts it knows, including two overwrites of one word where only the last must count and words in the register bank that lie past its depth. A design that dropped the XOR popcount, mixed up the two targets, or ignored the polarity flip between passes would report counts that differ from the bench's sums. It holds `rec_ready` low for many cycles, where a design that did not stall would lose or change the record. It stops and restarts the loop, where a design that reset its index or totals would break the count sequence. It drives the totals past their narrow bench width, where a wrapping adder would show a small value in place of all ones.

// File: rtl/rum_pkg.sv
package rum_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_WRITE  = 3'd1,
    PH_DWELL  = 3'd2,
    PH_READ   = 3'd3,
    PH_DRAIN  = 3'd4,
    PH_REPORT = 3'd5
  } phase_t;

endpackage

// File: rtl/rum_popcount.sv
module rum_popcount #(
  parameter int W = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  din,
  output logic [CW-1:0] ones
);

  always_comb begin
    ones = '0;
    for (int i = 0; i < W; i++) begin
      ones = ones + CW'(din[i]);
    end
  end

endmodule

// File: rtl/rum_ram_bank.sv
module rum_ram_bank #(
  parameter int WORDS = 1024,
  parameter int W     = 32,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

  AST_RAM_NO_RW_OVERLAP: assert property (@(posedge clk) !(we && re)); // R6

endmodule

// File: rtl/rum_reg_bank.sv
module rum_reg_bank #(
  parameter int WORDS = 64,
  parameter int W     = 32,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] regs [WORDS];
  logic [W-1:0] sel;

  always_ff @(posedge clk) begin
    for (int i = 0; i < WORDS; i++) begin
      if (we && waddr == AW'(i)) regs[i] <= wdata;
    end
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < WORDS; i++) begin
      if (raddr == AW'(i)) sel = regs[i];
    end
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= sel;
  end

endmodule

// File: rtl/rad_upset_monitor.sv
module rad_upset_monitor
  import rum_pkg::*;
#(
  parameter int RAM_WORDS    = 1024,
  parameter int REG_WORDS    = 64,
  parameter int DATA_W       = 32,
  parameter int DWELL_CYCLES = 50_000_000,
  parameter int TOT_W        = 32,
  parameter int IDX_W        = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic inj_en,
  input  logic inj_sel,
  input  logic [$clog2((RAM_WORDS > REG_WORDS) ? RAM_WORDS : REG_WORDS)-1:0] inj_addr,
  input  logic [DATA_W-1:0] inj_data,
  output logic rec_valid,
  input  logic rec_ready,
  output logic [IDX_W-1:0] rec_idx,
  output logic [$clog2(RAM_WORDS*DATA_W+1)-1:0] rec_ram_err,
  output logic [$clog2(REG_WORDS*DATA_W+1)-1:0] rec_reg_err,
  output logic [2:0] st_phase,
  output logic [TOT_W-1:0] st_ram_total,
  output logic [TOT_W-1:0] st_reg_total
);

  localparam int MAX_WORDS = (RAM_WORDS > REG_WORDS) ? RAM_WORDS : REG_WORDS;
  localparam int ADDR_W    = $clog2(MAX_WORDS);
  localparam int RAM_AW    = $clog2(RAM_WORDS);
  localparam int REG_AW    = $clog2(REG_WORDS);
  localparam int RCNT_W    = $clog2(RAM_WORDS*DATA_W+1);
  localparam int GCNT_W    = $clog2(REG_WORDS*DATA_W+1);
  localparam int PC_W      = $clog2(DATA_W+1);
  localparam int DW_W      = $clog2(DWELL_CYCLES+1);
  localparam int SUM_W     = ((TOT_W > RCNT_W) ? TOT_W : RCNT_W) + 1;
  localparam logic [ADDR_W-1:0] A_LAST  = ADDR_W'(MAX_WORDS-1);
  localparam logic [ADDR_W:0]   RAM_LIM = (ADDR_W+1)'(RAM_WORDS);
  localparam logic [ADDR_W:0]   REG_LIM = (ADDR_W+1)'(REG_WORDS);
  localparam logic [DW_W-1:0]   DW_LAST = DW_W'(DWELL_CYCLES-1);
  localparam logic [SUM_W-1:0]  SAT_MAX = SUM_W'({TOT_W{1'b1}});

  phase_t              phase;
  logic [ADDR_W-1:0]   addr;
  logic [DW_W-1:0]     dwell_cnt;
  logic [IDX_W-1:0]    cyc_idx;
  logic                rd_vld_q;
  logic [ADDR_W-1:0]   rd_addr_q;
  logic [RCNT_W-1:0]   ram_acc;
  logic [GCNT_W-1:0]   reg_acc;

  function automatic logic [DATA_W-1:0] pat_word(input logic [ADDR_W-1:0] a, input logic p);
    logic [DATA_W-1:0] w;
    for (int j = 0; j < DATA_W; j++) w[j] = ~(j[0] ^ a[0] ^ p);
    return w;
  endfunction

  // target port steering: sequencer in write/read, emulation in dwell
  logic in_wr, in_rd, in_dw, pol;
  logic addr_in_ram, addr_in_reg, inj_in_ram, inj_in_reg, q_in_ram, q_in_reg;
  logic ram_we, reg_we, ram_re, reg_re;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data, exp_word, ram_rdata, reg_rdata;
  logic [PC_W-1:0]   ram_pc, reg_pc;

  assign in_wr = (phase == PH_WRITE);
  assign in_rd = (phase == PH_READ);
  assign in_dw = (phase == PH_DWELL);
  assign pol   = cyc_idx[0];

  assign addr_in_ram = {1'b0, addr}      < RAM_LIM;
  assign addr_in_reg = {1'b0, addr}      < REG_LIM;
  assign inj_in_ram  = {1'b0, inj_addr}  < RAM_LIM;
  assign inj_in_reg  = {1'b0, inj_addr}  < REG_LIM;
  assign q_in_ram    = {1'b0, rd_addr_q} < RAM_LIM;
  assign q_in_reg    = {1'b0, rd_addr_q} < REG_LIM;

  assign ram_we  = (in_wr && addr_in_ram) || (in_dw && inj_en && !inj_sel && inj_in_ram);
  assign reg_we  = (in_wr && addr_in_reg) || (in_dw && inj_en &&  inj_sel && inj_in_reg);
  assign ram_re  = in_rd && addr_in_ram;
  assign reg_re  = in_rd && addr_in_reg;
  assign wr_addr = in_dw ? inj_addr : addr;
  assign wr_data = in_dw ? inj_data : pat_word(addr, pol);

  rum_ram_bank #(.WORDS(RAM_WORDS), .W(DATA_W)) ram_i (
    .clk(clk), .we(ram_we), .waddr(wr_addr[RAM_AW-1:0]), .wdata(wr_data),
    .re(ram_re), .raddr(addr[RAM_AW-1:0]), .rdata(ram_rdata)
  );

  rum_reg_bank #(.WORDS(REG_WORDS), .W(DATA_W)) reg_i (
    .clk(clk), .we(reg_we), .waddr(wr_addr[REG_AW-1:0]), .wdata(wr_data),
    .re(reg_re), .raddr(addr[REG_AW-1:0]), .rdata(reg_rdata)
  );

  assign exp_word = pat_word(rd_addr_q, pol);

  rum_popcount #(.W(DATA_W)) ram_pc_i (.din(ram_rdata ^ exp_word), .ones(ram_pc));
  rum_popcount #(.W(DATA_W)) reg_pc_i (.din(reg_rdata ^ exp_word), .ones(reg_pc));

  // saturating totals
  logic [SUM_W-1:0] ram_sum, reg_sum;
  logic [TOT_W-1:0] ram_tot_nx, reg_tot_nx;

  always_comb begin
    ram_sum = SUM_W'(st_ram_total) + SUM_W'(rec_ram_err);
    reg_sum = SUM_W'(st_reg_total) + SUM_W'(rec_reg_err);
    ram_tot_nx = (ram_sum > SAT_MAX) ? {TOT_W{1'b1}} : ram_sum[TOT_W-1:0];
    reg_tot_nx = (reg_sum > SAT_MAX) ? {TOT_W{1'b1}} : reg_sum[TOT_W-1:0];
  end

  wire accept = rec_valid && rec_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase        <= PH_IDLE;
      addr         <= '0;
      dwell_cnt    <= '0;
      cyc_idx      <= '0;
      rd_vld_q     <= 1'b0;
      rd_addr_q    <= '0;
      ram_acc      <= '0;
      reg_acc      <= '0;
      rec_valid    <= 1'b0;
      rec_idx      <= '0;
      rec_ram_err  <= '0;
      rec_reg_err  <= '0;
      st_ram_total <= '0;
      st_reg_total <= '0;
    end else begin
      rd_vld_q  <= in_rd;
      rd_addr_q <= addr;
      if (rd_vld_q && q_in_ram) ram_acc <= ram_acc + RCNT_W'(ram_pc);
      if (rd_vld_q && q_in_reg) reg_acc <= reg_acc + GCNT_W'(reg_pc);

      unique case (phase)
        PH_IDLE: begin
          if (run) begin
            phase <= PH_WRITE;
            addr  <= '0;
          end
        end
        PH_WRITE: begin
          if (addr == A_LAST) begin
            addr      <= '0;
            dwell_cnt <= '0;
            phase     <= PH_DWELL;
          end else begin
            addr <= addr + 1'b1;
          end
        end
        PH_DWELL: begin
          if (dwell_cnt == DW_LAST) phase <= PH_READ;
          else dwell_cnt <= dwell_cnt + 1'b1;
        end
        PH_READ: begin
          if (addr == A_LAST) phase <= PH_DRAIN;
          else addr <= addr + 1'b1;
        end
        PH_DRAIN: phase <= PH_REPORT;
        PH_REPORT: begin
          if (!rec_valid) begin
            rec_valid   <= 1'b1;
            rec_idx     <= cyc_idx;
            rec_ram_err <= ram_acc;
            rec_reg_err <= reg_acc;
          end else if (rec_ready) begin
            rec_valid    <= 1'b0;
            st_ram_total <= ram_tot_nx;
            st_reg_total <= reg_tot_nx;
            cyc_idx      <= cyc_idx + 1'b1;
            ram_acc      <= '0;
            reg_acc      <= '0;
            addr         <= '0;
            phase        <= run ? PH_WRITE : PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign st_phase = phase;

  AST_REC_HOLD: assert property (@(posedge clk) disable iff (rst)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_idx) && $stable(rec_ram_err) && $stable(rec_reg_err)); // R7
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    accept |=> cyc_idx == IDX_W'($past(cyc_idx) + 1'b1)); // R7
  AST_WRITE_THEN_DWELL: assert property (@(posedge clk) disable iff (rst)
    phase == PH_WRITE |=> phase == PH_WRITE || phase == PH_DWELL); // R5
  AST_DWELL_THEN_READ: assert property (@(posedge clk) disable iff (rst)
    phase == PH_DWELL |=> phase == PH_DWELL || phase == PH_READ); // R5
  AST_RAM_TOT_NO_DROP: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(st_ram_total) && $stable(st_reg_total)); // R9
  AST_TOT_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
    accept |=> st_ram_total >= $past(st_ram_total) && st_reg_total >= $past(st_reg_total)); // R9
  AST_WRITE_PHASES: assert property (@(posedge clk) disable iff (rst)
    (ram_we || reg_we) |-> (phase == PH_WRITE || phase == PH_DWELL)); // R6
  AST_LOOP_CONTINUES: assert property (@(posedge clk) disable iff (rst)
    accept && run |=> phase == PH_WRITE); // R10

endmodule

// File: tb/rad_upset_monitor_tb_top.sv
module rad_upset_monitor_tb_top;

  localparam int RAMW  = 16;
  localparam int REGW  = 8;
  localparam int DW    = 32;
  localparam int DWELL = 40;
  localparam int TOTW  = 10;
  localparam int IDXW  = 8;
  localparam int TOTMAX = (1 << TOTW) - 1;

  logic clk = 1'b0;
  logic rst, run, inj_en, inj_sel, rec_ready, rec_valid;
  logic [3:0] inj_addr;
  logic [DW-1:0] inj_data;
  logic [IDXW-1:0] rec_idx;
  logic [9:0] rec_ram_err;
  logic [8:0] rec_reg_err;
  logic [2:0] st_phase;
  logic [TOTW-1:0] st_ram_total, st_reg_total;

  int n_tests = 0;
  int n_fail  = 0;
  int exp_idx = 0;
  int exp_ram_tot = 0;
  int exp_reg_tot = 0;

  always #10 clk = ~clk;

  rad_upset_monitor #(
    .RAM_WORDS(RAMW), .REG_WORDS(REGW), .DATA_W(DW),
    .DWELL_CYCLES(DWELL), .TOT_W(TOTW), .IDX_W(IDXW)
  ) dut_i (
    .clk(clk), .rst(rst), .run(run), .inj_en(inj_en), .inj_sel(inj_sel),
    .inj_addr(inj_addr), .inj_data(inj_data), .rec_valid(rec_valid),
    .rec_ready(rec_ready), .rec_idx(rec_idx), .rec_ram_err(rec_ram_err),
    .rec_reg_err(rec_reg_err), .st_phase(st_phase),
    .st_ram_total(st_ram_total), .st_reg_total(st_reg_total)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] tb_pat(input int a, input int n);
    logic [DW-1:0] w;
    for (int j = 0; j < DW; j++) w[j] = ((j + a + n) % 2 == 0);
    return w;
  endfunction

  function automatic int sat(input int v);
    return (v > TOTMAX) ? TOTMAX : v;
  endfunction

  task automatic wait_phase(input int p);
    while (st_phase != 3'(p)) @(negedge clk);
  endtask

  task automatic inject(input logic sel, input int a, input logic [DW-1:0] d);
    inj_en = 1'b1; inj_sel = sel; inj_addr = 4'(a); inj_data = d;
    @(negedge clk);
    inj_en = 1'b0;
  endtask

  task automatic take_record(input string req, input int exp_ram, input int exp_reg);
    while (!rec_valid) @(negedge clk);
    chk("R7", "record index", rec_idx, exp_idx % 256);
    chk(req, "RAM errors", rec_ram_err, exp_ram);
    chk(req, "register errors", rec_reg_err, exp_reg);
    rec_ready = 1'b1;
    @(negedge clk);
    rec_ready = 1'b0;
    exp_ram_tot = sat(exp_ram_tot + exp_ram);
    exp_reg_tot = sat(exp_reg_tot + exp_reg);
    chk("R9", "RAM total", st_ram_total, exp_ram_tot);
    chk("R9", "register total", st_reg_total, exp_reg_tot);
    chk(run ? "R10" : "R8", "phase after accept", st_phase, run ? 1 : 0);
    exp_idx++;
  endtask

  task automatic t_reset();
    rst = 1'b1; run = 1'b0; inj_en = 1'b0; inj_sel = 1'b0; inj_addr = '0;
    inj_data = '0; rec_ready = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "phase after reset", st_phase, 0);
    chk("R1", "rec_valid after reset", rec_valid, 0);
    chk("R1", "RAM total after reset", st_ram_total, 0);
    chk("R1", "register total after reset", st_reg_total, 0);
    repeat (6) @(negedge clk);
    chk("R1", "idle while run low", st_phase, 0);
  endtask

  task automatic t_clean();
    run = 1'b1;
    @(negedge clk);
    chk("R8", "start from idle", st_phase, 1);
    take_record("R2", 0, 0);
  endtask

  task automatic t_ram_upsets();
    wait_phase(2);
    inject(1'b0, 3, tb_pat(3, exp_idx) ^ 32'h0000_0011);
    inject(1'b0, 7, tb_pat(7, exp_idx) ^ 32'hFFFF_0000);
    inject(1'b0, 5, tb_pat(5, exp_idx) ^ 32'h0000_0001);
    inject(1'b0, 5, tb_pat(5, exp_idx) ^ 32'h0000_0007);
    take_record("R3", 21, 0);
  endtask

  task automatic t_reg_upsets();
    wait_phase(2);
    inject(1'b1, 1, tb_pat(1, exp_idx) ^ 32'h8000_0001);
    inject(1'b1, REGW-1, tb_pat(REGW-1, exp_idx) ^ 32'h0000_000F);
    inject(1'b0, 0, tb_pat(0, exp_idx) ^ 32'h0000_0100);
    take_record("R4", 1, 6);
  endtask

  task automatic t_out_of_range();
    wait_phase(2);
    inject(1'b1, 9, 32'h0000_0000);
    inject(1'b1, 12, 32'hFFFF_FFFF);
    take_record("R6", 0, 0);
  endtask

  task automatic t_dwell_len();
    int cnt = 0;
    wait_phase(2);
    while (st_phase == 3'd2) begin
      cnt++;
      @(negedge clk);
    end
    chk("R5", "dwell length", cnt, DWELL);
    chk("R5", "phase after dwell", st_phase, 3);
    take_record("R5", 0, 0);
  endtask

  task automatic t_stall();
    logic [IDXW-1:0] held;
    while (!rec_valid) @(negedge clk);
    held = rec_idx;
    repeat (20) @(negedge clk);
    chk("R7", "valid held in stall", rec_valid, 1);
    chk("R7", "phase held in stall", st_phase, 5);
    chk("R7", "index stable in stall", rec_idx, held);
    take_record("R7", 0, 0);
  endtask

  task automatic t_stop_restart();
    wait_phase(2);
    run = 1'b0;
    take_record("R8", 0, 0);
    repeat (10) @(negedge clk);
    chk("R8", "stays idle after stop", st_phase, 0);
    chk("R8", "no record while stopped", rec_valid, 0);
    chk("R8", "RAM total kept while stopped", st_ram_total, exp_ram_tot);
    run = 1'b1;
    @(negedge clk);
    chk("R8", "restart enters write", st_phase, 1);
    take_record("R8", 0, 0);
  endtask

  task automatic t_saturate();
    for (int k = 0; k < 2; k++) begin
      wait_phase(2);
      for (int a = 0; a < RAMW; a++) inject(1'b0, a, ~tb_pat(a, exp_idx));
      take_record("R9", RAMW * DW, 0);
    end
    chk("R9", "RAM total saturated", st_ram_total, TOTMAX);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_clean();
    t_ram_upsets();
    t_reg_upsets();
    t_out_of_range();
    t_dwell_len();
    t_stall();
    t_stop_restart();
    t_saturate();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule